// File: doc/BRIEF.md
# Trigger-Driven Character Stream Editor

This block rewrites a stream of 8-bit ASCII characters on its way from an AXI4-Stream slave port to an AXI4-Stream master port. Certain uppercase letters act as triggers. Depending on the trigger, the block replaces characters with a fill character (`y` by default), removes them, or inserts fill characters into the stream. All other characters pass through unchanged and in order.

Each incoming character first lands in a one-word holding stage. A control state machine reads that stage in parallel with the data, so it sees the next character before it leaves. When the block must emit fill characters ahead of that character, or must look at the character that follows a trigger, it keeps the character in the holding stage. This costs cycles, but the state machine can then parse the character. A registered output stage feeds the master port. Each state advances only on a handshake it actually depends on. Fill characters emitted after a trigger need only output space, not new input, so back-pressure on either side cannot stall the block for good.

Top module: `stream_rewriter`

## Requirements
- R1: Lowercase letters, digits, and uppercase letters that are not triggers (including `W` outside the V case) pass through unchanged and in order.
- R2: Fill ranges: every character between a start and a stop trigger becomes the fill character. For A..B both triggers are kept. For C..D the start is dropped and the stop kept. For E..F the start is kept and the stop dropped. For G..H both are dropped.
- R3: The character `Z` is removed from the stream.
- R4: Delete ranges: every character between a start and a stop trigger is removed. For I..J both triggers are kept. For K..L the start is dropped and the stop kept. For M..N the start is kept and the stop dropped. For O..P both are dropped.
- R5: One fill character is placed before each `Q` and after each `R`.
- R6: Three fill characters are placed before `S` and after `T`. `U` is replaced by three fill characters.
- R7: When `V` is immediately followed by `W`, three fill characters are placed between them. When `V` is followed by any other character, that character is handled as ordinary input.
- R8: While a fill or delete range is open, any trigger other than that range's stop trigger is treated as plain data.
- R9: While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` hold. No character is lost or duplicated under any pattern of stalls on either port.
- R10: After reset, `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input character valid |
| s_ready | output | 1 | Block can accept an input character |
| s_data | input | 8 | Input character |
| m_valid | output | 1 | Output character valid |
| m_ready | input | 1 | Downstream accepts the output character |
| m_data | output | 8 | Output character |

## Verification
The bench targets the places where an insert must keep the next character in view. These are `V` followed by `W`, `Q` and `S` inserting ahead of the held character, and back-to-back triggers such as `QRS`. A design that let the held character slip past the state machine would leave out fills or emit them in the wrong place. A design that waited for new input before finishing a trailing insert would hang once the input ran dry, and the drain would come up short. Every sequence is run once with both ports always ready and once with random stalls on both sides. Hold checks on the master port would catch a design that changed data under back-pressure. Nested-trigger cases check that a range only closes on its own stop character.

// File: rtl/stream_rewriter.sv
module stream_rewriter #(
  parameter logic [7:0] FILL_CHAR = 8'h79
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data
);

  typedef enum logic [2:0] {
    ST_PASS, ST_SWAP, ST_DEL, ST_PRE, ST_POST, ST_VSEEN
  } state_t;

  state_t     st, n_st;
  logic       cur_v, o_v;
  logic [7:0] cur_d, o_d, stop_ch, n_stop, emit_d;
  logic       keep, n_keep, emit, take, go;
  logic [1:0] cnt, n_cnt;

  assign go      = !o_v || m_ready;
  assign s_ready = !cur_v || take;
  assign m_valid = o_v;
  assign m_data  = o_d;

  always_comb begin
    n_st   = st;
    n_stop = stop_ch;
    n_keep = keep;
    n_cnt  = cnt;
    emit   = 1'b0;
    emit_d = cur_d;
    take   = 1'b0;
    if (go) begin
      if (st == ST_POST) begin
        emit   = 1'b1;
        emit_d = FILL_CHAR;
        n_cnt  = cnt - 2'd1;
        if (cnt == 2'd1) n_st = ST_PASS;
      end else if (cur_v) begin
        case (st)
          ST_SWAP: begin
            take = 1'b1;
            if (cur_d == stop_ch) begin
              emit = keep;
              n_st = ST_PASS;
            end else begin
              emit   = 1'b1;
              emit_d = FILL_CHAR;
            end
          end
          ST_DEL: begin
            take = 1'b1;
            if (cur_d == stop_ch) begin
              emit = keep;
              n_st = ST_PASS;
            end
          end
          ST_PRE: begin
            emit = 1'b1;
            if (cnt != 2'd0) begin
              emit_d = FILL_CHAR;
              n_cnt  = cnt - 2'd1;
            end else begin
              take = 1'b1;
              n_st = ST_PASS;
            end
          end
          default: begin
            if (st == ST_VSEEN && cur_d == 8'h57) begin
              emit   = 1'b1;
              emit_d = FILL_CHAR;
              n_st   = ST_PRE;
              n_cnt  = 2'd2;
            end else begin
              n_st = ST_PASS;
              take = 1'b1;
              emit = 1'b1;
              case (cur_d)
                8'h41: begin n_st = ST_SWAP; n_stop = 8'h42; n_keep = 1'b1; end
                8'h43: begin n_st = ST_SWAP; n_stop = 8'h44; n_keep = 1'b1; emit = 1'b0; end
                8'h45: begin n_st = ST_SWAP; n_stop = 8'h46; n_keep = 1'b0; end
                8'h47: begin n_st = ST_SWAP; n_stop = 8'h48; n_keep = 1'b0; emit = 1'b0; end
                8'h5A: emit = 1'b0;
                8'h49: begin n_st = ST_DEL; n_stop = 8'h4A; n_keep = 1'b1; end
                8'h4B: begin n_st = ST_DEL; n_stop = 8'h4C; n_keep = 1'b1; emit = 1'b0; end
                8'h4D: begin n_st = ST_DEL; n_stop = 8'h4E; n_keep = 1'b0; end
                8'h4F: begin n_st = ST_DEL; n_stop = 8'h50; n_keep = 1'b0; emit = 1'b0; end
                8'h51: begin take = 1'b0; emit_d = FILL_CHAR; n_st = ST_PRE; n_cnt = 2'd0; end
                8'h52: begin n_st = ST_POST; n_cnt = 2'd1; end
                8'h53: begin take = 1'b0; emit_d = FILL_CHAR; n_st = ST_PRE; n_cnt = 2'd2; end
                8'h54: begin n_st = ST_POST; n_cnt = 2'd3; end
                8'h55: begin n_st = ST_POST; n_cnt = 2'd3; emit = 1'b0; end
                8'h56: n_st = ST_VSEEN;
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PASS;
      stop_ch <= 8'h00;
      keep    <= 1'b0;
      cnt     <= 2'd0;
      cur_v   <= 1'b0;
      cur_d   <= 8'h00;
      o_v     <= 1'b0;
      o_d     <= 8'h00;
    end else begin
      st      <= n_st;
      stop_ch <= n_stop;
      keep    <= n_keep;
      cnt     <= n_cnt;
      if (s_valid && s_ready) begin
        cur_v <= 1'b1;
        cur_d <= s_data;
      end else if (take) begin
        cur_v <= 1'b0;
      end
      if (emit) begin
        o_v <= 1'b1;
        o_d <= emit_d;
      end else if (m_ready) begin
        o_v <= 1'b0;
      end
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  // R9
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_v && !s_ready |=> cur_v && $stable(cur_d));

  // R2
  swap_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SWAP && cur_v && go && cur_d != stop_ch |=> m_valid && m_data == FILL_CHAR);

  // R4
  del_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_DEL && cur_v && go && cur_d != stop_ch |=> !m_valid);

  // R6
  post_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_POST && go |=> m_valid && m_data == FILL_CHAR);

endmodule

// File: tb/test_stream_rewriter.sv
module test_stream_rewriter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, s_ready;
  logic [7:0] s_data = 8'h00;
  logic       m_valid, m_ready = 1'b0;
  logic [7:0] m_data;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stream_rewriter i_stream_rewriter (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  task automatic check_str(string tag, string act, string exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=\"%s\" expected=\"%s\"", tag, act, exp);
    end
  endtask

  task automatic run_stream(string tag, string din, bit stall, output string dout);
    int idx = 0;
    int idle = 0;
    bit held = 1'b0;
    logic [7:0] held_d = 8'h00;
    dout = "";
    for (int cyc = 0; cyc < 3000 && idle < 40; cyc++) begin
      @(negedge clk);
      if (held) begin
        checks++;
        if (!m_valid || m_data != held_d) begin
          failures++;
          $display("FAIL R9 %s hold actual=%0d/%h expected=1/%h", tag, m_valid, m_data, held_d);
        end
      end
      s_valid = (idx < din.len()) && (!stall || ($urandom % 3 != 0));
      s_data  = (idx < din.len()) ? din[idx] : 8'h00;
      m_ready = !stall || ($urandom % 4 != 0);
      #1;
      held   = m_valid && !m_ready;
      held_d = m_data;
      if (s_valid && s_ready) idx++;
      if (m_valid && m_ready) begin
        dout = $sformatf("%s%c", dout, m_data);
        idle = 0;
      end else if (idx >= din.len()) begin
        idle++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    m_ready = 1'b0;
  endtask

  task automatic run_case(string tag, string din, string exp);
    string got;
    run_stream(tag, din, 1'b0, got);
    check_str({tag, " free"}, got, exp);
    run_stream(tag, din, 1'b1, got);
    check_str({tag, " stalled"}, got, exp);
  endtask

  task automatic test_reset;
    checks++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      failures++;
      $display("FAIL R10 actual m_valid=%b s_ready=%b expected 0/1", m_valid, s_ready);
    end
  endtask

  task automatic test_pass;     run_case("R1", "hello World 42", "hello World 42"); endtask
  task automatic test_swap;
    run_case("R2 A..B", "aaaAxxxBbbb", "aaaAyyyBbbb");
    run_case("R2 C..D", "aaaCxxxDbbb", "aaayyyDbbb");
    run_case("R2 E..F", "aaaExxxFbbb", "aaaEyyybbb");
    run_case("R2 G..H", "aaaGxxxHbbb", "aaayyybbb");
  endtask
  task automatic test_zap;      run_case("R3", "ZaZbZ", "ab"); endtask
  task automatic test_delete;
    run_case("R4 I..J", "aaaIxxxJbbb", "aaaIJbbb");
    run_case("R4 K..L", "aaaKxxxLbbb", "aaaLbbb");
    run_case("R4 M..N", "aaaMxxxNbbb", "aaaMbbb");
    run_case("R4 O..P", "aaaOxxxPbbb", "aaabbb");
  endtask
  task automatic test_single;
    run_case("R5 Q", "aaaQbbb", "aaayQbbb");
    run_case("R5 R", "aaaRbbb", "aaaRybbb");
    run_case("R5 R tail", "aR", "aRy");
  endtask
  task automatic test_seq;
    run_case("R6 S", "aaaSbbb", "aaayyySbbb");
    run_case("R6 T", "aaaTbbb", "aaaTyyybbb");
    run_case("R6 U", "aaaUbbb", "aaayyybbb");
    run_case("R6 QRS", "QRS", "yQRyyyyS");
  endtask
  task automatic test_vw;
    run_case("R7 VW", "aaVWbb", "aaVyyyWbb");
    run_case("R7 V other", "aVbW", "aVbW");
    run_case("R7 V trig", "VZW", "VW");
  endtask
  task automatic test_nested;
    run_case("R8 swap", "aAxIZBb", "aAyyyBb");
    run_case("R8 del", "aIxQxJb", "aIJb");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_pass();
    test_swap();
    test_zap();
    test_delete();
    test_single();
    test_seq();
    test_vw();
    test_nested();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule